// File: doc/BRIEF.md
# Serial Transmit Port with Coarse Bit Delay and Alignment Pattern

This block is the transmit half of a front-end serial link. It runs on the bit-rate shift clock, eight times the word rate. Once every eight clock cycles it loads one parallel word into a shift register. It then sends that word out one bit per clock, most significant bit first. The word comes from one of three sources: the upstream data stream, a fixed alignment pattern, or an idle word. The alignment pattern and the idle word both contain edges, so the receiver's fine phase tracking always sees transitions, even when no data is flowing.

A coarse delay setting of 0 to 7 bit periods moves the word boundary seen on the serial line. This lets a receiving deserialiser find all eight bits of a word inside one of its own frames. A new delay setting is adopted only at a word boundary. The word period that follows such a change is marked by `slip_flag`, because that word may be cut or repeat bits. The `word_start` output marks the cycle in which a word's first bit is on the line.

The data input uses valid/ready flow control. `in_ready` is high for one cycle in every eight, and only when the pattern is not selected. A word transfers in a cycle where both `in_valid` and `in_ready` are high. The source may hold `in_valid` and `in_data` for as long as it likes; the word is taken only in the ready cycle. If no valid word is offered in that cycle, the idle word goes out instead. The serial line never stalls.

Top module: `ser_tx_aligner`

## Requirements
- R1: In the first clock cycle after reset is released, `ser_out` is 0, `slip_flag` is 0 and `in_ready` is 1. That cycle is a word boundary.
- R2: The word loaded at a boundary is sent on the undelayed bit stream during the 8 cycles that follow, bit 7 first and bit 0 last.
- R3: Word boundaries fall every 8 cycles. `in_ready` is high only in a boundary cycle. A word is taken only when `in_valid` and `in_ready` are both high. A word held valid across other cycles is sent exactly once.
- R4: If `pat_sel` is 1 in a boundary cycle, the pattern 8'hFE (1111_1110) is loaded and `in_ready` stays 0. The offered data word is not consumed and stays pending for a later boundary.
- R5: If `pat_sel` is 0 and `in_valid` is 0 in a boundary cycle, the idle word 8'hCA (1100_1010) is loaded. Every loaded word therefore has at least one edge, unless upstream data supplies a constant word.
- R6: With an applied delay d (0 to 7), `ser_out` in cycle t equals the undelayed bit stream in cycle t−d.
- R7: `delay_bits` is sampled only in boundary cycles. A value present at any other cycle has no effect on `ser_out`.
- R8: `slip_flag` is 1 for the 8 cycles after a boundary at which the sampled delay differs from the delay in use before it. Otherwise it is 0.
- R9: `word_start` is 1 in exactly the cycle that is d cycles after the first cycle of a loaded word, d being the delay applied at that load. In that cycle `ser_out` carries the word's bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate shift clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream word is valid |
| in_ready | output | 1 | Word accepted in this cycle if valid |
| in_data | input | 8 | Upstream parallel word |
| pat_sel | input | 1 | Send alignment pattern instead of data |
| delay_bits | input | 3 | Coarse bit delay, 0 to 7 |
| ser_out | output | 1 | Serial bit stream, MSB first |
| word_start | output | 1 | Marks the bit-7 cycle of each delayed word |
| slip_flag | output | 1 | Marks the word period after a delay change |

## Verification
Data words with mixed bit values (A5, 3C, 96, 69) show whether bit order and the boundary position are right. A byte swap or a one-cycle load skew corrupts them, whereas a symmetric word could hide it. A word offered early and held valid tests that back-pressure neither drops nor duplicates it. Holding data while the pattern is selected shows that the pattern wins and the data is kept for the next boundary. Every delay from 1 to 7 is applied in turn, each followed by a steady period, so a wrong tap shows as shifted bits and a wrong flag shows in the steady period. A delay glitch between boundaries must leave the stream untouched.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  // Source of the word loaded at a boundary
  typedef enum logic [1:0] {
    SRC_DATA    = 2'd0,
    SRC_PATTERN = 2'd1,
    SRC_IDLE    = 2'd2
  } word_src_e;

  localparam int unsigned DEF_WORD_W = 8;

endpackage

// File: rtl/ser_word_sel.sv
module ser_word_sel
  import ser_tx_pkg::*;
#(
  parameter int unsigned    W       = DEF_WORD_W,
  parameter logic [W-1:0]   PATTERN = 8'hFE,
  parameter logic [W-1:0]   IDLE    = 8'hCA
) (
  input  logic         boundary,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         pat_sel,
  output logic         in_ready,
  output logic [W-1:0] word,
  output word_src_e    src
);

  always_comb begin
    if (pat_sel) begin
      src  = SRC_PATTERN;
      word = PATTERN;
    end else if (in_valid) begin
      src  = SRC_DATA;
      word = in_data;
    end else begin
      src  = SRC_IDLE;
      word = IDLE;
    end
  end

  // Data is consumed only at a boundary where the pattern is not forced
  assign in_ready = boundary && !pat_sel;

  // Immediate check: pattern selection never consumes data
  always_comb begin
    if (pat_sel) begin
      AST_PAT_BLOCKS_READY: assert (!in_ready); // R4
    end
  end

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_tx_pkg::*;
#(
  parameter int unsigned W  = DEF_WORD_W,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word,
  output logic          boundary,
  output logic [PW-1:0] phase,
  output logic          raw_bit
);

  localparam logic [PW-1:0] LAST_PH = PW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [PW-1:0] ph_q;

  // Reset parks the phase on the last slot so the first cycle is a boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= LAST_PH;
      sh_q <= '0;
    end else if (ph_q == LAST_PH) begin
      ph_q <= '0;
      sh_q <= word;
    end else begin
      ph_q <= ph_q + PW'(1);
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign boundary = (ph_q == LAST_PH);
  assign phase    = ph_q;
  assign raw_bit  = sh_q[W-1];

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> raw_bit == $past(word[W-1])); // R2

  AST_BOUNDARY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !boundary); // R3

endmodule

// File: rtl/ser_slip.sv
module ser_slip
  import ser_tx_pkg::*;
#(
  parameter int unsigned W  = DEF_WORD_W,
  localparam int unsigned DW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_bit,
  input  logic          boundary,
  input  logic [DW-1:0] phase,
  input  logic [DW-1:0] delay_bits,
  output logic          ser_out,
  output logic          word_start,
  output logic          slip_flag
);

  logic [W-1:1]  hist_q;
  logic [W-1:0]  taps;
  logic [DW-1:0] dly_q;
  logic          slip_q;

  // taps[k] is the undelayed bit from k cycles ago
  assign taps = {hist_q, raw_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= taps[W-2:0];
    end
  end

  // Delay and its change marker move only at a word boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q  <= '0;
      slip_q <= 1'b0;
    end else if (boundary) begin
      dly_q  <= delay_bits;
      slip_q <= (delay_bits != dly_q);
    end
  end

  assign ser_out    = taps[dly_q];
  assign word_start = (phase == dly_q);
  assign slip_flag  = slip_q;

  AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(dly_q)); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(slip_flag)); // R8

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (delay_bits == dly_q)) |=> !slip_flag); // R8

  AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q == '0) |-> (ser_out == raw_bit)); // R6

endmodule

// File: rtl/ser_tx_aligner.sv
module ser_tx_aligner
  import ser_tx_pkg::*;
#(
  parameter int unsigned  W       = DEF_WORD_W,
  parameter logic [W-1:0] PATTERN = 8'hFE,
  parameter logic [W-1:0] IDLE    = 8'hCA,
  localparam int unsigned DW      = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pat_sel,
  input  logic [DW-1:0] delay_bits,
  output logic          ser_out,
  output logic          word_start,
  output logic          slip_flag
);

  logic          boundary;
  logic [DW-1:0] phase;
  logic [W-1:0]  word;
  logic          raw_bit;
  word_src_e     src;

  ser_word_sel #(.W(W), .PATTERN(PATTERN), .IDLE(IDLE)) u_sel (
    .boundary (boundary),
    .in_valid (in_valid),
    .in_data  (in_data),
    .pat_sel  (pat_sel),
    .in_ready (in_ready),
    .word     (word),
    .src      (src)
  );

  ser_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (word),
    .boundary (boundary),
    .phase    (phase),
    .raw_bit  (raw_bit)
  );

  ser_slip #(.W(W)) u_slip (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_bit    (raw_bit),
    .boundary   (boundary),
    .phase      (phase),
    .delay_bits (delay_bits),
    .ser_out    (ser_out),
    .word_start (word_start),
    .slip_flag  (slip_flag)
  );

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && src == SRC_IDLE) |=> raw_bit == IDLE[W-1]); // R5

  AST_PATTERN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && src == SRC_PATTERN) |=> raw_bit == PATTERN[W-1]); // R4

  AST_READY_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R3

endmodule

// File: tb/sim_ser_tx_aligner.sv
module sim_ser_tx_aligner;

  localparam int N = 4096;
  localparam logic [7:0] PAT  = 8'hFE;
  localparam logic [7:0] IDLW = 8'hCA;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       pat_sel = 1'b0;
  logic [2:0] delay_bits = 3'd0;
  logic       ser_out, word_start, slip_flag;

  int nchk = 0, nfail = 0;
  int cyc = 0, rel = -1, last_d = 0;
  logic ob[N], ows[N], osl[N], ordy[N];
  logic ex_raw[N], ex_ws[N], ex_sl[N], ex_rdy[N];
  int   ex_d[N];

  always #5 clk = ~clk;

  ser_tx_aligner u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pat_sel(pat_sel), .delay_bits(delay_bits),
    .ser_out(ser_out), .word_start(word_start), .slip_flag(slip_flag)
  );

  function automatic bit is_bnd(int c);
    return (rel >= 0) && (c >= rel) && (((c - rel) % 8) == 0);
  endfunction

  // Monitor and requirement model: samples mid-cycle, after input changes
  always begin
    @(posedge clk);
    cyc++;
    #7;
    if (cyc < N - 16) begin
      ob[cyc] = ser_out; ows[cyc] = word_start;
      osl[cyc] = slip_flag; ordy[cyc] = in_ready;
      if (rst_n && rel < 0) rel = cyc;
      ex_rdy[cyc] = is_bnd(cyc) && !pat_sel;
      if (is_bnd(cyc)) begin
        logic [7:0] w;
        w = pat_sel ? PAT : (in_valid ? in_data : IDLW);
        for (int j = 0; j < 8; j++) begin
          ex_raw[cyc+1+j] = w[7-j];
          ex_d[cyc+1+j]   = int'(delay_bits);
          ex_sl[cyc+1+j]  = (int'(delay_bits) != last_d);
        end
        ex_ws[cyc+1+int'(delay_bits)] = 1'b1;
        last_d = int'(delay_bits);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] word_at(int s);
    logic [7:0] w;
    for (int j = 0; j < 8; j++) w[7-j] = ob[s+j];
    return w;
  endfunction

  function automatic logic exp_out(int t);
    return (t - ex_d[t] >= 0) ? ex_raw[t - ex_d[t]] : 1'b0;
  endfunction

  task automatic check_window(input int a, input int b, input string tag);
    for (int t = a; t < b; t++) begin
      chk(ob[t] === exp_out(t), {tag, " R6 stream"}, int'(ob[t]), int'(exp_out(t)));
      chk(ows[t] === ex_ws[t], "R9 word_start", int'(ows[t]), int'(ex_ws[t]));
      chk(osl[t] === ex_sl[t], "R8 slip_flag", int'(osl[t]), int'(ex_sl[t]));
      chk(ordy[t] === ex_rdy[t], "R3 in_ready", int'(ordy[t]), int'(ex_rdy[t]));
    end
  endtask

  // Returns at the negedge of the next boundary cycle; index in rb
  task automatic to_bnd(output int rb);
    @(negedge clk);
    while (!is_bnd(cyc)) @(negedge clk);
    rb = cyc;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    #2;
    chk(ser_out === 1'b0, "R1 ser_out", int'(ser_out), 0);
    chk(slip_flag === 1'b0, "R1 slip_flag", int'(slip_flag), 0);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_stream;
    int r0, r1, r2, s;
    s = cyc;
    delay_bits = 3'd0;
    to_bnd(r0); in_valid = 1'b1; in_data = 8'hA5;
    to_bnd(r1); in_data = 8'h3C;
    to_bnd(r2); in_data = 8'h00;
    @(negedge clk); in_valid = 1'b0;
    wait_cyc(10);
    chk(word_at(r0+1) == 8'hA5, "R2 word A5", word_at(r0+1), 8'hA5);
    chk(word_at(r1+1) == 8'h3C, "R2 word 3C", word_at(r1+1), 8'h3C);
    chk(word_at(r2+1) == 8'h00, "R2 word 00", word_at(r2+1), 8'h00);
    check_window(s + 1, cyc - 1, "R2");
  endtask

  task automatic t_backpressure;
    int rb, s;
    s = cyc;
    to_bnd(rb);
    @(negedge clk); @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A;
    to_bnd(rb);
    @(negedge clk); in_valid = 1'b0;
    wait_cyc(18);
    chk(word_at(rb+1) == 8'h5A, "R3 held word sent", word_at(rb+1), 8'h5A);
    chk(word_at(rb+9) == IDLW, "R3 sent once then idle", word_at(rb+9), IDLW);
    check_window(s + 1, cyc - 1, "R3");
  endtask

  task automatic t_pattern;
    int rb, s;
    s = cyc;
    to_bnd(rb);
    in_valid = 1'b1; in_data = 8'h12; pat_sel = 1'b1;
    #2;
    chk(in_ready === 1'b0, "R4 ready low with pattern", int'(in_ready), 0);
    @(negedge clk); pat_sel = 1'b0;
    to_bnd(rb);
    @(negedge clk); in_valid = 1'b0;
    wait_cyc(10);
    chk(word_at(rb-7) == PAT, "R4 pattern word", word_at(rb-7), PAT);
    chk(word_at(rb+1) == 8'h12, "R4 data kept pending", word_at(rb+1), 8'h12);
    check_window(s + 1, cyc - 1, "R4");
  endtask

  task automatic t_idle;
    int rb, s, edges;
    s = cyc;
    to_bnd(rb);
    wait_cyc(18);
    chk(word_at(rb+1) == IDLW, "R5 idle word", word_at(rb+1), IDLW);
    chk(word_at(rb+9) == IDLW, "R5 idle word again", word_at(rb+9), IDLW);
    edges = 0;
    for (int t = rb + 2; t <= rb + 8; t++) if (ob[t] != ob[t-1]) edges++;
    chk(edges > 0, "R5 edges present", edges, 1);
    check_window(s + 1, cyc - 1, "R5");
  endtask

  task automatic t_delays;
    int r1, r2, s;
    s = cyc;
    for (int d = 1; d < 8; d++) begin
      to_bnd(r1); delay_bits = 3'(d); in_valid = 1'b1; in_data = 8'h96;
      to_bnd(r2); in_data = 8'h69;
      @(negedge clk); in_valid = 1'b0;
      wait_cyc(16);
      chk(word_at(r1+1+d) == 8'h96, "R6 delayed word", word_at(r1+1+d), 8'h96);
      chk(ows[r1+1+d] === 1'b1, "R9 start on MSB", int'(ows[r1+1+d]), 1);
      chk(osl[r1+1] === 1'b1 && osl[r1+8] === 1'b1, "R8 flag after change",
          int'(osl[r1+8]), 1);
      chk(osl[r2+1] === 1'b0 && osl[r2+8] === 1'b0, "R8 flag clear when steady",
          int'(osl[r2+1]), 0);
    end
    check_window(s + 1, cyc - 1, "R6");
  endtask

  task automatic t_midword;
    int rb, s;
    to_bnd(rb); delay_bits = 3'd3;
    to_bnd(rb);
    s = rb;
    in_valid = 1'b1; in_data = 8'hC3;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); delay_bits = 3'd6;
    @(negedge clk); @(negedge clk); delay_bits = 3'd3;
    wait_cyc(14);
    chk(word_at(rb+4) == 8'hC3, "R7 glitch ignored", word_at(rb+4), 8'hC3);
    chk(osl[rb+9] === 1'b0, "R7 no flag from glitch", int'(osl[rb+9]), 0);
    check_window(s + 1, cyc - 1, "R7");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      ex_raw[i] = 1'b0; ex_ws[i] = 1'b0; ex_sl[i] = 1'b0; ex_rdy[i] = 1'b0; ex_d[i] = 0;
    end
    t_reset();
    t_stream();
    t_backpressure();
    t_pattern();
    t_idle();
    t_delays();
    t_midword();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule